// File: doc/BRIEF.md
# TDM Receive Deserializer with Frame-Sync Watchdog

This block takes one serial time-division-multiplexed receive link (a bit clock, a frame-start marker and a data line) and turns it into bytes for a downstream cell-delineation stage. Each delivered byte carries the index of the timeslot it came from. Only timeslots enabled in a per-slot mapping vector are delivered. A link is framed either as a 32-slot frame of 256 bits or as a 24-slot frame of 193 bits whose first bit is a framing bit. The link may run in a fixed-format bus mode with fixed edge and marker polarities, or in a generic mode where both polarities are programmable.

The three link inputs are oversampled on the block's own clock. The link clock is always an input and is never generated here. A synchronizer chain of `SYNC_STAGES` flops leads to an edge detector, which produces one sample event per selected link-clock edge. A frame position counter is realigned by the frame marker. It also watches the marker period: a marker at a position other than the frame start, or a frame start reached with no marker, sets a sticky error flag. Once that flag is set, only the clear input resets it. When the unit is disabled, its byte outputs are released to high impedance and its frame lock is dropped.

Top module: `tdm_rx_deser`

## Requirements
- R1: While reset is asserted with the unit enabled, `byte_vld_o` and `sync_err_o` are 0, and `byte_o` and `slot_o` are 0.
- R2: Bits are assembled MSB first: the first sampled bit of a timeslot becomes bit 7 of the byte. `byte_vld_o` is high for exactly one clock per delivered byte, and `byte_o` and `slot_o` are valid during that clock.
- R3: With `t1_mode_i`=0 a frame is 256 bits. The bit sampled with the frame marker active is position 0, and timeslot n (0..31) occupies positions 8n..8n+7.
- R4: With `t1_mode_i`=1 a frame is 193 bits. Position 0 is a framing bit that is never delivered, timeslot n (0..23) occupies positions 1+8n..8+8n, and no slot index above 23 is ever delivered.
- R5: Timeslot n is delivered only when `slot_map_i[n]`=1. In 193-bit mode, map bits 24..31 have no effect.
- R6: With `generic_mode_i`=0, data and marker are sampled on the falling link-clock edge and the marker is active low, whatever the values of `clk_pol_i` and `sync_pol_i`.
- R7: With `generic_mode_i`=1, `clk_pol_i`=0 samples on the rising edge and 1 on the falling edge. `sync_pol_i`=0 makes the marker active high and 1 makes it active low.
- R8: Once locked, a marker sampled at any position other than the expected frame start sets `sync_err_o`. A frame start reached without a marker also sets it. A correctly placed marker, or any marker before lock, leaves it clear.
- R9: A marker that arrives at an unexpected position restarts the frame at that bit, and later bytes are delivered relative to the new frame start.
- R10: `sync_err_o` stays at 1 until `err_clr_i` is high at a clock edge. If a new error and a clear coincide, the flag stays set.
- R11: While `en_i`=0, no byte is delivered, `byte_o`, `slot_o` and `byte_vld_o` are high impedance, and lock is dropped. After re-enabling, the first marker locks without raising an error.
- R12: No byte is delivered after reset or enabling until the first frame marker has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Unit enable; 0 tri-states the byte outputs and drops lock |
| t1_mode_i | input | 1 | 1: 193-bit/24-slot frame, 0: 256-bit/32-slot frame |
| generic_mode_i | input | 1 | 1: generic mode with programmable polarity, 0: fixed bus mode |
| clk_pol_i | input | 1 | Generic mode sample edge: 0 rising, 1 falling |
| sync_pol_i | input | 1 | Generic mode marker level: 0 active high, 1 active low |
| slot_map_i | input | 32 | Per-timeslot delivery enable, bit n for slot n |
| err_clr_i | input | 1 | Clears the sticky marker error flag |
| rx_clk_i | input | 1 | Link bit clock |
| rx_sync_i | input | 1 | Link frame marker |
| rx_dat_i | input | 1 | Link serial data |
| byte_o | output | 8 | Assembled timeslot byte |
| byte_vld_o | output | 1 | One-clock strobe for a delivered byte |
| slot_o | output | 5 | Timeslot index of the delivered byte |
| sync_err_o | output | 1 | Sticky misplaced or missing marker flag |

## Verification
A link-clock transition that reaches the sampling edge shows up as a delivered byte or as a change of the error flag. That result appears in the clock cycle after the third rising `clk` edge that follows the transition: two synchronizer stages plus the output register. The bench holds every link bit for eight clocks, four before and four after the sampling edge. Every byte and flag update is therefore settled before the bench drives the next bit. Outputs are captured at the falling `clk` edge by a monitor that logs every strobe. Error-flag and byte-count checks run only at the end of a whole bit period, never at a guessed cycle inside it.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int BYTE_W        = 8;
  localparam int E1_SLOTS      = 32;
  localparam int T1_SLOTS      = 24;
  localparam int E1_FRAME_BITS = E1_SLOTS * BYTE_W;
  localparam int T1_FRAME_BITS = T1_SLOTS * BYTE_W + 1;
  localparam int POS_W         = $clog2(E1_FRAME_BITS);
  localparam int SLOT_W        = $clog2(E1_SLOTS);
  localparam int BIT_W         = $clog2(BYTE_W);

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [BYTE_W-1:0] data;
  } rx_byte_t;
endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk_i,
  input  logic rx_sync_i,
  input  logic rx_dat_i,
  input  logic generic_i,
  input  logic clk_pol_i,
  input  logic sync_pol_i,
  output logic samp_o,
  output logic sync_act_o,
  output logic dat_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] clk_sr_q, clk_sr_d;
  logic [LAST:0] sync_sr_q, sync_sr_d;
  logic [LAST:0] dat_sr_q, dat_sr_d;
  logic          clk_prev_q;
  logic          fall_sel, low_sel, cur_lvl;

  always_comb begin
    clk_sr_d  = {clk_sr_q[LAST-1:0], rx_clk_i};
    sync_sr_d = {sync_sr_q[LAST-1:0], rx_sync_i};
    dat_sr_d  = {dat_sr_q[LAST-1:0], rx_dat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sr_q   <= '0;
      sync_sr_q  <= '0;
      dat_sr_q   <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_sr_q   <= clk_sr_d;
      sync_sr_q  <= sync_sr_d;
      dat_sr_q   <= dat_sr_d;
      clk_prev_q <= clk_sr_q[LAST];
    end
  end

  always_comb begin
    fall_sel   = generic_i ? clk_pol_i  : 1'b1;
    low_sel    = generic_i ? sync_pol_i : 1'b1;
    cur_lvl    = clk_sr_q[LAST];
    samp_o     = fall_sel ? (clk_prev_q & ~cur_lvl) : (~clk_prev_q & cur_lvl);
    sync_act_o = sync_sr_q[LAST] ^ low_sel;
    dat_o      = dat_sr_q[LAST];
  end

  AST_ONE_SAMPLE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |=> !samp_o); // R7
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             t1_i,
  input  logic             samp_i,
  input  logic             sync_act_i,
  input  logic             err_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             locked_o,
  output logic             sync_err_o
);
  logic [POS_W-1:0] pos_q, pos_d, last_pos, step_pos, cur_pos;
  logic             locked_q, locked_d;
  logic             err_q, err_d;
  logic             at_end, misplaced, state_en;

  always_comb begin
    last_pos  = t1_i ? POS_W'(T1_FRAME_BITS - 1) : POS_W'(E1_FRAME_BITS - 1);
    at_end    = (pos_q >= last_pos);
    step_pos  = at_end ? '0 : pos_q + POS_W'(1);
    cur_pos   = sync_act_i ? '0 : step_pos;
    misplaced = en_i & samp_i & locked_q & (sync_act_i ^ at_end);
    state_en  = ~en_i | samp_i;
    if (!en_i) begin
      pos_d    = '0;
      locked_d = 1'b0;
    end else begin
      pos_d    = cur_pos;
      locked_d = locked_q | sync_act_i;
    end
    if (misplaced)      err_d = 1'b1;
    else if (err_clr_i) err_d = 1'b0;
    else                err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (state_en) begin
      pos_q    <= pos_d;
      locked_q <= locked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign pos_o      = cur_pos;
  assign locked_o   = locked_q | sync_act_i;
  assign sync_err_o = err_q;

  AST_REALIGN_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && samp_i && sync_act_i) |=> (pos_q == '0)); // R9
  AST_ERR_ONLY_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(samp_i)); // R8
  AST_NO_ERR_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && !err_q) |=> !err_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr_i) |=> err_q); // R10
endmodule

// File: rtl/tdm_rx_packer.sv
module tdm_rx_packer
  import tdm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                t1_i,
  input  logic [E1_SLOTS-1:0] slot_map_i,
  input  logic                samp_i,
  input  logic                dat_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                locked_i,
  output rx_byte_t            byte_o,
  output logic                vld_o
);
  logic [BYTE_W-2:0]   sh_q, sh_d;
  logic [POS_W-1:0]    offset;
  logic [BIT_W-1:0]    bit_idx;
  logic [SLOT_W-1:0]   slot_idx;
  logic [E1_SLOTS-1:0] slot_ok;
  logic                payload, emit;
  rx_byte_t            byte_q, byte_d;
  logic                vld_q;

  for (genvar g = 0; g < E1_SLOTS; g++) begin : g_slot_ok
    if (g < T1_SLOTS) begin : g_common
      assign slot_ok[g] = slot_map_i[g];
    end else begin : g_e1_only
      assign slot_ok[g] = slot_map_i[g] & ~t1_i;
    end
  end

  always_comb begin
    sh_d        = {sh_q[BYTE_W-3:0], dat_i};
    payload     = ~(t1_i & (pos_i == '0));
    offset      = t1_i ? pos_i - POS_W'(1) : pos_i;
    bit_idx     = offset[BIT_W-1:0];
    slot_idx    = offset[POS_W-1:BIT_W];
    emit        = en_i & samp_i & locked_i & payload &
                  (bit_idx == BIT_W'(BYTE_W - 1)) & slot_ok[slot_idx];
    byte_d.data = {sh_q, dat_i};
    byte_d.slot = slot_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (samp_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    byte_q <= '0;
    else if (emit) byte_q <= byte_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= emit;
  end

  assign byte_o = byte_q;
  assign vld_o  = vld_q;

  AST_T1_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(t1_i)) |-> (byte_q.slot < SLOT_W'(T1_SLOTS))); // R4
  AST_LAST_BIT_IN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (byte_q.data[0] == $past(dat_i))); // R2
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              t1_mode_i,
  input  logic              generic_mode_i,
  input  logic              clk_pol_i,
  input  logic              sync_pol_i,
  input  logic [31:0]       slot_map_i,
  input  logic              err_clr_i,
  input  logic              rx_clk_i,
  input  logic              rx_sync_i,
  input  logic              rx_dat_i,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o,
  output logic [4:0]        slot_o,
  output logic              sync_err_o
);
  logic             samp, sync_act, dat_s, locked;
  logic [POS_W-1:0] pos;
  rx_byte_t         pk_byte;
  logic             pk_vld;

  tdm_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_clk_i   (rx_clk_i),
    .rx_sync_i  (rx_sync_i),
    .rx_dat_i   (rx_dat_i),
    .generic_i  (generic_mode_i),
    .clk_pol_i  (clk_pol_i),
    .sync_pol_i (sync_pol_i),
    .samp_o     (samp),
    .sync_act_o (sync_act),
    .dat_o      (dat_s)
  );

  tdm_rx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .t1_i       (t1_mode_i),
    .samp_i     (samp),
    .sync_act_i (sync_act),
    .err_clr_i  (err_clr_i),
    .pos_o      (pos),
    .locked_o   (locked),
    .sync_err_o (sync_err_o)
  );

  tdm_rx_packer u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .t1_i       (t1_mode_i),
    .slot_map_i (slot_map_i),
    .samp_i     (samp),
    .dat_i      (dat_s),
    .pos_i      (pos),
    .locked_i   (locked),
    .byte_o     (pk_byte),
    .vld_o      (pk_vld)
  );

  assign byte_o     = en_i ? pk_byte.data : 8'bz;
  assign slot_o     = en_i ? pk_byte.slot : 5'bz;
  assign byte_vld_o = en_i ? pk_vld       : 1'bz;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pk_vld |=> !pk_vld); // R2
  AST_MAP_GATES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pk_vld |-> ((($past(slot_map_i) >> pk_byte.slot) & 32'd1) == 32'd1)); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pk_vld); // R11
endmodule

// File: tb/tdm_rx_deser_bench.sv
module tdm_rx_deser_bench;
  logic        clk = 1'b0;
  logic        rst_n, en_i, t1_mode_i, generic_mode_i, clk_pol_i, sync_pol_i;
  logic [31:0] slot_map_i;
  logic        err_clr_i, rx_clk_i, rx_sync_i, rx_dat_i;
  wire  [7:0]  byte_o;
  wire         byte_vld_o;
  wire  [4:0]  slot_o;
  wire         sync_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit exp_locked = 1'b0;

  logic [7:0] exp_d [0:1023];
  logic [4:0] exp_s [0:1023];
  logic [7:0] act_d [0:1023];
  logic [4:0] act_s [0:1023];
  int exp_n = 0;
  int act_n = 0;

  always #10 clk = ~clk;

  tdm_rx_deser u_tdm_rx_deser (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .t1_mode_i(t1_mode_i),
    .generic_mode_i(generic_mode_i), .clk_pol_i(clk_pol_i), .sync_pol_i(sync_pol_i),
    .slot_map_i(slot_map_i), .err_clr_i(err_clr_i), .rx_clk_i(rx_clk_i),
    .rx_sync_i(rx_sync_i), .rx_dat_i(rx_dat_i), .byte_o(byte_o),
    .byte_vld_o(byte_vld_o), .slot_o(slot_o), .sync_err_o(sync_err_o)
  );

  always @(negedge clk) begin
    if (byte_vld_o === 1'b1 && act_n < 1024) begin
      act_d[act_n] = byte_o;
      act_s[act_n] = slot_o;
      act_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit samp_fall();
    return generic_mode_i ? clk_pol_i : 1'b1;
  endfunction

  function automatic bit sync_low();
    return generic_mode_i ? sync_pol_i : 1'b1;
  endfunction

  function automatic logic [7:0] pat(input int slot, input int fr);
    return 8'((slot * 37 + fr * 59 + 27) & 255);
  endfunction

  task automatic drive_bit(input bit d, input bit s);
    rx_clk_i  = samp_fall();
    rx_dat_i  = d;
    rx_sync_i = s ^ sync_low();
    repeat (4) @(negedge clk);
    rx_clk_i = ~samp_fall();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int fr, input int nbits, input bit with_sync);
    for (int p = 0; p < nbits; p++) begin
      int off;
      int sl;
      int b;
      bit d;
      bit s;
      s = with_sync && (p == 0);
      if (t1_mode_i && p == 0) begin
        d = fr[0];
        b = 0;
        sl = 0;
      end else begin
        off = p - (t1_mode_i ? 1 : 0);
        sl = off / 8;
        b = off % 8;
        d = pat(sl, fr)[7 - b];
      end
      if (s && en_i) exp_locked = 1'b1;
      drive_bit(d, s);
      if (!(t1_mode_i && p == 0) && b == 7 && exp_locked && en_i && slot_map_i[sl]) begin
        exp_d[exp_n] = pat(sl, fr);
        exp_s[exp_n] = 5'(sl);
        exp_n++;
      end
    end
  endtask

  task automatic compare(input string req);
    chk(act_n == exp_n, req, act_n, exp_n);
    for (int i = 0; i < exp_n && i < act_n; i++)
      chk(act_d[i] == exp_d[i] && act_s[i] == exp_s[i], req,
          {act_s[i], act_d[i]}, {exp_s[i], exp_d[i]});
    act_n = 0;
    exp_n = 0;
  endtask

  task automatic set_cfg(input bit t1, input bit gen, input bit cp, input bit sp,
                         input logic [31:0] map);
    en_i = 1'b0;
    exp_locked = 1'b0;
    t1_mode_i = t1;
    generic_mode_i = gen;
    clk_pol_i = cp;
    sync_pol_i = sp;
    slot_map_i = map;
    rx_clk_i = samp_fall();
    rx_sync_i = sync_low();
    repeat (6) @(negedge clk);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_err();
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en_i = 1'b1;
    t1_mode_i = 1'b0;
    generic_mode_i = 1'b1;
    clk_pol_i = 1'b0;
    sync_pol_i = 1'b0;
    slot_map_i = '1;
    err_clr_i = 1'b0;
    rx_clk_i = 1'b0;
    rx_sync_i = 1'b0;
    rx_dat_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state with the unit enabled
    chk(byte_vld_o === 1'b0, "R1 strobe in reset", int'(byte_vld_o), 0);
    chk(sync_err_o === 1'b0, "R1 flag in reset", int'(sync_err_o), 0);
    chk(byte_o === 8'h00 && slot_o === 5'h00, "R1 byte/slot in reset", int'(byte_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep: frame format x mode x polarities, map varied per configuration
    for (int cfg = 0; cfg < 10; cfg++) begin
      logic [63:0] rot;
      int sub;
      bit gen;
      sub = cfg % 5;
      gen = (sub != 4);
      rot = {32'h9E3779B9, 32'h9E3779B9} >> (cfg * 3);
      // bus-mode configurations drive polarity bits opposite to the fixed ones (R6)
      set_cfg(cfg >= 5, gen, gen ? sub[0] : 1'b0, gen ? sub[1] : 1'b0, rot[31:0]);
      send_frame(cfg * 3, t1_mode_i ? 193 : 256, 1'b0);
      compare("R12 no bytes before first marker");
      send_frame(cfg * 3 + 1, t1_mode_i ? 193 : 256, 1'b1);
      send_frame(cfg * 3 + 2, t1_mode_i ? 193 : 256, 1'b1);
      // R2 R3 R4 R5 R6 R7: slot contents, order, mapping and sampling conventions
      compare(t1_mode_i ? "R2/R4/R5/R6/R7 193-bit sweep" : "R2/R3/R5/R6/R7 256-bit sweep");
      chk(sync_err_o === 1'b0, "R8 no flag for well-placed markers", int'(sync_err_o), 0);
    end

    // Misplaced marker, realignment and sticky flag
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
    send_frame(40, 256, 1'b1);
    send_frame(41, 20, 1'b1);
    compare("R3 partial frame slots");
    chk(sync_err_o === 1'b0, "R8 flag before early marker", int'(sync_err_o), 0);
    send_frame(42, 256, 1'b1);
    chk(sync_err_o === 1'b1, "R8 early marker flagged", int'(sync_err_o), 1);
    compare("R9 bytes realigned to early marker");
    repeat (20) @(negedge clk);
    chk(sync_err_o === 1'b1, "R10 flag held without clear", int'(sync_err_o), 1);
    clear_err();
    chk(sync_err_o === 1'b0, "R10 flag cleared", int'(sync_err_o), 0);
    send_frame(43, 256, 1'b1);
    chk(sync_err_o === 1'b0, "R8 no flag on correct marker", int'(sync_err_o), 0);
    send_frame(44, 256, 1'b0);
    chk(sync_err_o === 1'b1, "R8 missing marker flagged", int'(sync_err_o), 1);
    compare("R8 bytes continue through missing marker");
    clear_err();
    chk(sync_err_o === 1'b0, "R10 flag cleared again", int'(sync_err_o), 0);

    // Disabled unit
    en_i = 1'b0;
    exp_locked = 1'b0;
    repeat (4) @(negedge clk);
    send_frame(50, 256, 1'b1);
    compare("R11 nothing delivered while disabled");
    chk(byte_vld_o !== 1'b1, "R11 strobe idle while disabled", int'(byte_vld_o === 1'b1), 0);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(51, 256, 1'b1);
    send_frame(52, 256, 1'b1);
    chk(sync_err_o === 1'b0, "R11 relock without flag", int'(sync_err_o), 0);
    compare("R11 delivery after re-enable");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule